// File: doc/BRIEF.md
# SD Card Command Register Front-End

This block is the processor-facing register file of an SD card host controller. Software builds a command one byte at a time by writing the low byte of each access to a command port. When the sixth byte of a frame lands, the block decodes the frame into a command index, a 32-bit argument and a CRC byte. It then offers the decoded command to a downstream command engine over a valid/ready request. The engine answers with a one-cycle done pulse that carries a length code and up to sixteen response bytes.

The block captures the response into a small buffer and reshapes it according to its length. Software reads the buffer back one byte per access through the same command port. A separate data port passes 32-bit words straight to and from the engine, with the most significant byte first on the card side. Control registers hold a clock divider, transfer enables and start bits, and drive them out to the engine. A pending register reflects the receive enables. When no card is present, both ports return all-ones and ignore writes. After a command with index 0 has been issued, the block discards the next command-port write, so that software can clock the card's initialisation with a dummy byte.

Top module: `sdc_regfront`

## Requirements
- R1: After reset, word offsets 0 to 3 and the unused offsets 6 and 7 read 0. With a card present, a command-port read returns 0x00.
- R2: Offsets 0 (clock divider), 1 (enable) and 3 (start) store and read back the full 32-bit written value. `clk_div` drives the divider, `xfer_enable` drives enable bits [3:0], and `xfer_start` drives start bits [1:0].
- R3: Offset 2 (pending) reads enable bit 1 in bit 1 and enable bit 3 in bit 3. All its other bits read 0, and a write to it changes nothing.
- R4: Six accepted writes to offset 4 fill a frame, byte k taken from bits [7:0] of the k-th write. The sixth write raises `req_valid` one cycle later with `req_index` = byte0[5:0], `req_arg` = bytes 1..4 (byte 1 most significant) and `req_crc` = byte 5. The request holds steady until `req_ready`.
- R5: `cmd_busy` is high from the cycle after the sixth write until the cycle after `rsp_done` is taken. Command-port writes made while busy are dropped and do not advance the frame position.
- R6: On `rsp_done`, buffer byte 0 takes the command index and bytes 1..16 take `rsp_bytes`, with byte 1 = `rsp_bytes[127:120]`. The read position returns to 0. `rsp_len` code 0 (none) or 3 gives length 0.
- R7: Code 2 (16-byte reply) replaces buffer byte 0 with 0x3F and gives length 17. A read at position 17 returns 0x00.
- R8: Code 1 (4-byte reply) forces buffer byte 5 to 0x00 and gives length 6.
- R9: Each present command-port read returns the buffer byte at the read position and then advances it. The read at position equal to the length wraps the position to 0 and raises `rsp_overrun` for one cycle.
- R10: After a command with index 0 is issued, the next present command-port write is discarded without advancing the frame position.
- R11: With `card_present` low, command-port reads return 0xFF and data-port reads return 0xFFFFFFFF. Writes to either port have no effect: no data strobe is raised and no frame byte is taken.
- R12: A present data-port write raises `dat_wr_valid` in the same cycle with `dat_wr_word` equal to the written word. A present data-port read raises `dat_rd_req` and returns `dat_rd_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Card inserted |
| bus_addr | input | 3 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| cmd_busy | output | 1 | Command in flight; command writes dropped |
| rsp_overrun | output | 1 | One-cycle pulse when the read position wraps |
| clk_div | output | 32 | Clock divider value |
| xfer_enable | output | 4 | Transfer enables: cmd tx, cmd rx, data tx, data rx |
| xfer_start | output | 2 | Start bits: cmd tx, data rx |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_crc | output | 8 | Command CRC byte |
| rsp_done | input | 1 | Response available pulse |
| rsp_len | input | 2 | Response length code |
| rsp_bytes | input | 128 | Response bytes, first in bits [127:120] |
| dat_wr_valid | output | 1 | Data word to engine |
| dat_wr_word | output | 32 | Data word, most significant byte first |
| dat_rd_req | output | 1 | Data word taken from engine |
| dat_rd_word | input | 32 | Data word from engine |

## Verification
A wrong frame position or a missed discard shows at the very next issued request as a shifted index, argument or CRC. A stale read position or a wrong length shows within one response read-back as a misplaced byte or an overrun pulse in the wrong cycle. A stuck busy state shows in the cycle after `rsp_done`, because `cmd_busy` stays high and the next frame never raises a request.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int WORD_W    = 32;
    localparam int FRAME_LEN = 6;
    localparam int FRAME_W   = FRAME_LEN * 8;
    localparam int RSP_MAX   = 16;
    localparam int BUF_LEN   = RSP_MAX + 1;
    localparam int PTR_W     = $clog2(BUF_LEN + 1);
    localparam int FPTR_W    = $clog2(FRAME_LEN);
    localparam int ADDR_W    = 3;

    localparam logic [WORD_W-1:0] PEND_RX_MASK = 32'h0000_000A;
    localparam logic [7:0]        LONG_TAG     = 8'h3F;
    localparam int                SHORT_PAD_AT = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIV   = 3'd0,
        OFS_EN    = 3'd1,
        OFS_PEND  = 3'd2,
        OFS_START = 3'd3,
        OFS_CMD   = 3'd4,
        OFS_DATA  = 3'd5
    } reg_ofs_e;

    typedef enum logic [1:0] {
        RLEN_NONE  = 2'd0,
        RLEN_SHORT = 2'd1,
        RLEN_LONG  = 2'd2,
        RLEN_RSVD  = 2'd3
    } rsp_len_e;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_REQ  = 2'd1,
        FR_WAIT = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic [5:0]        index;
        logic [WORD_W-1:0] arg;
        logic [7:0]        crc;
    } sd_req_t;

    // byte 0 occupies the top byte of the frame vector
    function automatic sd_req_t decode_frame(input logic [FRAME_W-1:0] f);
        sd_req_t r;
        r.index = f[FRAME_W-3 -: 6];
        r.arg   = f[FRAME_W-9 -: WORD_W];
        r.crc   = f[7:0];
        return r;
    endfunction

    function automatic logic [PTR_W-1:0] shaped_len(input rsp_len_e c);
        case (c)
            RLEN_SHORT: return PTR_W'(6);
            RLEN_LONG:  return PTR_W'(BUF_LEN);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/sdc_cmd_framer.sv
module sdc_cmd_framer
    import sdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    byte_we,
    input  logic [7:0] byte_in,
    input  logic    req_ready,
    input  logic    rsp_done,
    output logic    req_valid,
    output sd_req_t req_o,
    output logic    busy,
    output logic    rsp_take
);

    fr_state_e            state_q;
    logic [FPTR_W-1:0]    wptr_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [FRAME_W-1:0]   frame_nx;
    logic                 skip_q;
    sd_req_t              req_q;
    sd_req_t              req_nx;
    logic                 last_byte;

    always_comb begin
        frame_nx = frame_q;
        frame_nx[(FRAME_LEN - 1 - int'(wptr_q)) * 8 +: 8] = byte_in;
        req_nx    = decode_frame(frame_nx);
        last_byte = (int'(wptr_q) == FRAME_LEN - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
            wptr_q  <= '0;
            frame_q <= '0;
            skip_q  <= 1'b0;
            req_q   <= '0;
        end else begin
            case (state_q)
                FR_IDLE: begin
                    if (byte_we) begin
                        if (skip_q) begin
                            skip_q <= 1'b0;
                        end else begin
                            frame_q <= frame_nx;
                            if (last_byte) begin
                                wptr_q  <= '0;
                                req_q   <= req_nx;
                                skip_q  <= (req_nx.index == 6'd0);
                                state_q <= FR_REQ;
                            end else begin
                                wptr_q <= wptr_q + 1'b1;
                            end
                        end
                    end
                end
                FR_REQ:  if (req_ready) state_q <= FR_WAIT;
                FR_WAIT: if (rsp_done)  state_q <= FR_IDLE;
                default: state_q <= FR_IDLE;
            endcase
        end
    end

    assign req_valid = (state_q == FR_REQ);
    assign req_o     = req_q;
    assign busy      = (state_q != FR_IDLE);
    assign rsp_take  = (state_q == FR_WAIT) && rsp_done;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_o)));

    // R4
    wptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(wptr_q) < FRAME_LEN);

    // R5
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wptr_q) || !busy);

endmodule

// File: rtl/sdc_rsp_buffer.sv
module sdc_rsp_buffer
    import sdc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [5:0]   index,
    input  rsp_len_e     code,
    input  logic [RSP_MAX*8-1:0] bytes,
    input  logic         rd_step,
    output logic [7:0]   cur_byte,
    output logic         overrun
);

    logic [7:0]       mem_q [BUF_LEN];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] len_q;
    logic             ovr_q;
    logic [PTR_W-1:0] ptr_inc;

    assign ptr_inc = ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_LEN; i++) mem_q[i] <= '0;
        end else if (load) begin
            mem_q[0] <= (code == RLEN_LONG) ? LONG_TAG : {2'b00, index};
            for (int i = 1; i < BUF_LEN; i++) begin
                if (i == SHORT_PAD_AT && code == RLEN_SHORT)
                    mem_q[i] <= 8'h00;
                else
                    mem_q[i] <= bytes[(RSP_MAX - i) * 8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            len_q <= '0;
            ovr_q <= 1'b0;
        end else if (load) begin
            ptr_q <= '0;
            len_q <= shaped_len(code);
            ovr_q <= 1'b0;
        end else if (rd_step) begin
            if (ptr_inc > len_q) begin
                ptr_q <= '0;
                ovr_q <= 1'b1;
            end else begin
                ptr_q <= ptr_inc;
                ovr_q <= 1'b0;
            end
        end else begin
            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        cur_byte = 8'h00;
        if (int'(ptr_q) < BUF_LEN) cur_byte = mem_q[ptr_q];
    end

    assign overrun = ovr_q;

    // R9
    rptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= len_q);

    // R9
    overrun_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (ptr_q == '0));

    // R6
    load_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (ptr_q == '0) && !overrun);

endmodule

// File: rtl/sdc_ctrl_regs.sv
module sdc_ctrl_regs
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] div_q,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] start_q,
    output logic [WORD_W-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            en_q    <= '0;
            start_q <= '0;
        end else if (wr) begin
            case (addr)
                OFS_DIV:   div_q   <= wdata;
                OFS_EN:    en_q    <= wdata;
                OFS_START: start_q <= wdata;
                default: ;
            endcase
        end
    end

    // receive flags follow their enables; a write here is re-covered at once
    assign pend = en_q & PEND_RX_MASK;

    // R3
    pend_tx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pend[0] == 1'b0) && (pend[2] == 1'b0));

endmodule

// File: rtl/sdc_regfront.sv
module sdc_regfront
    import sdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 card_present,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 cmd_busy,
    output logic                 rsp_overrun,
    output logic [31:0]          clk_div,
    output logic [3:0]           xfer_enable,
    output logic [1:0]           xfer_start,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [5:0]           req_index,
    output logic [31:0]          req_arg,
    output logic [7:0]           req_crc,
    input  logic                 rsp_done,
    input  logic [1:0]           rsp_len,
    input  logic [127:0]         rsp_bytes,
    output logic                 dat_wr_valid,
    output logic [31:0]          dat_wr_word,
    output logic                 dat_rd_req,
    input  logic [31:0]          dat_rd_word
);

    logic        sel_cmd, sel_dat;
    logic        byte_we, rd_step, rsp_take;
    logic [7:0]  cur_byte;
    sd_req_t     req_s;
    logic [WORD_W-1:0] div_q, en_q, start_q, pend;

    assign sel_cmd = (bus_addr == OFS_CMD);
    assign sel_dat = (bus_addr == OFS_DATA);
    assign byte_we = bus_wr && sel_cmd && card_present && !cmd_busy;
    assign rd_step = bus_rd && !bus_wr && sel_cmd && card_present;

    sdc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .div_q   (div_q),
        .en_q    (en_q),
        .start_q (start_q),
        .pend    (pend)
    );

    sdc_cmd_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .byte_we   (byte_we),
        .byte_in   (bus_wdata[7:0]),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .req_valid (req_valid),
        .req_o     (req_s),
        .busy      (cmd_busy),
        .rsp_take  (rsp_take)
    );

    sdc_rsp_buffer u_rsp (
        .clk      (clk),
        .rst      (rst),
        .load     (rsp_take),
        .index    (req_s.index),
        .code     (rsp_len_e'(rsp_len)),
        .bytes    (rsp_bytes),
        .rd_step  (rd_step),
        .cur_byte (cur_byte),
        .overrun  (rsp_overrun)
    );

    assign req_index   = req_s.index;
    assign req_arg     = req_s.arg;
    assign req_crc     = req_s.crc;
    assign clk_div     = div_q;
    assign xfer_enable = en_q[3:0];
    assign xfer_start  = start_q[1:0];

    assign dat_wr_valid = bus_wr && sel_dat && card_present;
    assign dat_wr_word  = bus_wdata;
    assign dat_rd_req   = bus_rd && !bus_wr && sel_dat && card_present;

    always_comb begin
        case (bus_addr)
            OFS_DIV:   bus_rdata = div_q;
            OFS_EN:    bus_rdata = en_q;
            OFS_PEND:  bus_rdata = pend;
            OFS_START: bus_rdata = start_q;
            OFS_CMD:   bus_rdata = card_present ? {24'h0, cur_byte} : 32'h0000_00FF;
            OFS_DATA:  bus_rdata = card_present ? dat_rd_word : 32'hFFFF_FFFF;
            default:   bus_rdata = '0;
        endcase
    end

    // R11
    absent_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !card_present |-> (!dat_wr_valid && !dat_rd_req && !$rose(req_valid)));

    // R5
    busy_no_reissue_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && !rsp_take) |=> cmd_busy);

    // R6
    take_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_take |-> (cmd_busy && !req_valid));

endmodule

// File: tb/tb_sdc_regfront.sv
module tb_sdc_regfront;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         card_present = 1'b1;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         cmd_busy, rsp_overrun;
    logic [31:0]  clk_div;
    logic [3:0]   xfer_enable;
    logic [1:0]   xfer_start;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic [7:0]   req_crc;
    logic         rsp_done = 1'b0;
    logic [1:0]   rsp_len = '0;
    logic [127:0] rsp_bytes = '0;
    logic         dat_wr_valid;
    logic [31:0]  dat_wr_word;
    logic         dat_rd_req;
    logic [31:0]  dat_rd_word = '0;

    int total = 0;
    int bad   = 0;
    logic        last_dwv;
    logic [31:0] last_dww;

    always #4 clk = ~clk;

    sdc_regfront dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        last_dwv = dat_wr_valid;
        last_dww = dat_wr_word;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output logic rq);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d  = bus_rdata;
        rq = dat_rd_req;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // six byte writes, engine handshake, checks of the request fields
    task automatic run_cmd(input logic [47:0] fr, input logic [1:0] code,
                           input logic [127:0] rb, input int ready_delay, input string tag);
        logic [31:0] ea;
        for (int k = 0; k < 6; k++) bus_write(3'd4, {24'h0, fr[47 - 8*k -: 8]});
        ea = fr[39:8];
        @(negedge clk);
        chk({tag, " R4 req_valid"}, {31'h0, req_valid}, 32'h1);
        chk({tag, " R4 index"}, {26'h0, req_index}, {26'h0, fr[45:40]});
        chk({tag, " R4 arg"}, req_arg, ea);
        chk({tag, " R4 crc"}, {24'h0, req_crc}, {24'h0, fr[7:0]});
        chk({tag, " R5 busy"}, {31'h0, cmd_busy}, 32'h1);
        for (int w = 0; w < ready_delay; w++) begin
            @(negedge clk);
            chk({tag, " R4 hold"}, {31'h0, req_valid}, 32'h1);
        end
        req_ready = 1'b1;
        @(posedge clk); #1;
        req_ready = 1'b0;
        @(negedge clk);
        rsp_done = 1'b1; rsp_len = code; rsp_bytes = rb;
        @(posedge clk); #1;
        rsp_done = 1'b0;
        chk({tag, " R5 idle"}, {31'h0, cmd_busy}, 32'h0);
    endtask

    function automatic logic [127:0] pattern(input logic [7:0] base);
        logic [127:0] v;
        for (int i = 1; i <= 16; i++) v[(16 - i) * 8 +: 8] = base + 8'(i);
        return v;
    endfunction

    task automatic t_reset();
        logic [31:0] d; logic rq;
        bus_read(3'd0, d, rq); chk("R1 div", d, 0);
        bus_read(3'd1, d, rq); chk("R1 enable", d, 0);
        bus_read(3'd2, d, rq); chk("R1 pending", d, 0);
        bus_read(3'd3, d, rq); chk("R1 start", d, 0);
        bus_read(3'd6, d, rq); chk("R1 unused", d, 0);
        bus_read(3'd4, d, rq); chk("R1 cmd", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d; logic rq;
        bus_write(3'd0, 32'h1234_5678);
        bus_write(3'd1, 32'hF0F0_000A);
        bus_write(3'd3, 32'hABCD_0003);
        bus_read(3'd0, d, rq); chk("R2 div", d, 32'h1234_5678);
        bus_read(3'd1, d, rq); chk("R2 enable", d, 32'hF0F0_000A);
        bus_read(3'd3, d, rq); chk("R2 start", d, 32'hABCD_0003);
        chk("R2 clk_div", clk_div, 32'h1234_5678);
        chk("R2 xfer_enable", {28'h0, xfer_enable}, 32'hA);
        chk("R2 xfer_start", {30'h0, xfer_start}, 32'h3);
        bus_read(3'd2, d, rq); chk("R3 pending rx", d, 32'hA);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, d, rq); chk("R3 pending after clear", d, 32'hA);
        bus_write(3'd1, 32'h5);
        bus_read(3'd2, d, rq); chk("R3 pending tx only", d, 32'h0);
        bus_write(3'd1, 32'h2);
        bus_read(3'd2, d, rq); chk("R3 pending cmd rx", d, 32'h2);
    endtask

    task automatic t_short();
        logic [31:0] d; logic rq;
        logic [7:0] exp [7] = '{8'h11, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'h00, 8'hC6};
        run_cmd(48'hD1_1234_5678_9B, 2'd1, pattern(8'hC0), 2, "short");
        for (int i = 0; i < 7; i++) begin
            bus_read(3'd4, d, rq);
            chk($sformatf("R8 R6 byte%0d", i), d, {24'h0, exp[i]});
            chk("R9 overrun timing", {31'h0, rsp_overrun}, (i == 6) ? 32'h1 : 32'h0);
        end
        bus_read(3'd4, d, rq); chk("R9 wrapped", d, 32'h11);
        chk("R9 overrun one cycle", {31'h0, rsp_overrun}, 0);
    endtask

    task automatic t_long();
        logic [31:0] d; logic rq;
        run_cmd(48'h02_0000_0000_55, 2'd2, pattern(8'h20), 0, "long");
        bus_read(3'd4, d, rq); chk("R7 tag", d, 32'h3F);
        for (int i = 1; i <= 16; i++) begin
            bus_read(3'd4, d, rq);
            chk($sformatf("R7 byte%0d", i), d, 32'h20 + i);
        end
        chk("R7 no early overrun", {31'h0, rsp_overrun}, 0);
        bus_read(3'd4, d, rq); chk("R7 past end", d, 0);
        chk("R7 R9 overrun", {31'h0, rsp_overrun}, 1);
    endtask

    task automatic t_none();
        logic [31:0] d; logic rq;
        run_cmd(48'h07_0000_0001_01, 2'd0, pattern(8'h70), 0, "none");
        for (int i = 0; i < 2; i++) begin
            bus_read(3'd4, d, rq); chk("R6 none index", d, 32'h07);
            chk("R6 none overrun", {31'h0, rsp_overrun}, 1);
        end
    endtask

    task automatic t_busy();
        bus_write(3'd4, 32'h08);
        for (int k = 1; k < 6; k++) bus_write(3'd4, 32'h10 + k);
        @(negedge clk);
        chk("R5 busy set", {31'h0, cmd_busy}, 1);
        bus_write(3'd4, 32'hEE);   // dropped while busy
        req_ready = 1'b1; @(posedge clk); #1; req_ready = 1'b0;
        bus_write(3'd4, 32'hEE);   // dropped in the wait state
        @(negedge clk);
        rsp_done = 1'b1; rsp_len = 2'd0;
        @(posedge clk); #1; rsp_done = 1'b0;
        run_cmd(48'h09_A1A2_A3A4_A5, 2'd0, '0, 1, "after busy R5");
    endtask

    task automatic t_cmd0();
        run_cmd(48'h40_0000_0000_95, 2'd0, '0, 0, "cmd0");
        bus_write(3'd4, 32'hFF);   // swallowed
        run_cmd(48'h05_0102_0304_77, 2'd1, pattern(8'h00), 0, "post cmd0 R10");
    endtask

    task automatic t_absent();
        logic [31:0] d; logic rq;
        card_present = 1'b0;
        bus_read(3'd4, d, rq); chk("R11 cmd read", d, 32'hFF);
        bus_read(3'd5, d, rq); chk("R11 data read", d, 32'hFFFF_FFFF);
        chk("R11 no rd req", {31'h0, rq}, 0);
        bus_write(3'd5, 32'h1111_2222);
        chk("R11 no wr strobe", {31'h0, last_dwv}, 0);
        for (int k = 0; k < 3; k++) bus_write(3'd4, 32'h3C);
        @(negedge clk);
        chk("R11 no request", {31'h0, req_valid}, 0);
        card_present = 1'b1;
        run_cmd(48'h0C_DEAD_BEEF_42, 2'd0, '0, 0, "present again R11");
    endtask

    task automatic t_data();
        logic [31:0] d; logic rq;
        bus_write(3'd5, 32'hCAFE_BABE);
        chk("R12 wr strobe", {31'h0, last_dwv}, 1);
        chk("R12 wr word", last_dww, 32'hCAFE_BABE);
        dat_rd_word = 32'h0102_0304;
        bus_read(3'd5, d, rq);
        chk("R12 rd word", d, 32'h0102_0304);
        chk("R12 rd req", {31'h0, rq}, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_short();
        t_long();
        t_none();
        t_busy();
        t_cmd0();
        t_absent();
        t_data();
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule